// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged Cache Lookup

This block is the tag-lookup step of a set-associative cache whose set is chosen from virtual address bits, so the tag array can be read while the address translation is still in flight. In the request cycle the caller presents the virtual set-index field. The tag array is read at the end of that cycle. In the following cycle the caller presents the translated physical frame number. The block compares every way's stored physical tag against it and registers the outcome. The outcome is a hit flag, the hitting way and a page-colour error flag.

With the default geometry a line is 64 bytes (6 offset bits) and there are 7 set-index bits. A page is 1 KB (10 untranslated bits). The top 3 set-index bits therefore lie above the page offset and form the page colour. The same split is used at full size: 16 index-plus-offset bits of which 13 are untranslated. A virtual alias whose colour differs from its physical page's colour would place one physical line in two sets. The block flags such a lookup and refuses the hit. A fill port installs a physical tag in a set, and a flush input invalidates every line.

Top module: `vipt_lookup`

## Requirements
- R1: After reset every line is invalid, `rsp_valid` is low, and every lookup misses.
- R2: A request accepted in cycle t takes `tr_pfn` in cycle t+1 and produces its result in cycle t+2, with `rsp_valid` high for exactly that one cycle.
- R3: The set is `req_vset`. The physical tag is `tr_pfn` bits above the low 3 colour bits, i.e. physical address bits [31:13]. A lookup hits when a valid way in that set holds this tag, and `rsp_way` gives that way's number.
- R4: The page colour is `req_vset[6:4]` on the virtual side and `tr_pfn[2:0]` on the physical side. When they differ, `rsp_colour_err` is 1, `rsp_hit` is 0 and `rsp_way` is 0, whatever the set holds.
- R5: A lookup with matching colours and no valid way holding the tag gives `rsp_hit` 0, `rsp_way` 0 and `rsp_colour_err` 0.
- R6: A fill of a tag not resident in its set writes way `p` of that set and marks it valid. `p` is a per-set pointer that starts at 0 after reset and advances by one per such fill, wrapping from 15 to 0. Sets do not share pointers.
- R7: A fill of a tag already valid in its set rewrites that same way and leaves the set's pointer unchanged.
- R8: A flush invalidates every line and leaves all pointers unchanged. A fill presented in the same cycle as a flush is dropped.
- R9: A lookup sees the array as it stood before its request cycle's edge. A fill in the request cycle is not visible to that lookup, but it is visible to a lookup requested one cycle later.
- R10: At most one way of a set hits for any lookup.
- R11: While `rsp_valid` is low, `rsp_hit`, `rsp_colour_err` and `rsp_way` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request |
| req_vset | input | 7 | Virtual set-index field (VA[12:6]) |
| tr_pfn | input | 22 | Translated frame number PA[31:10], sampled the cycle after the request |
| fill_valid | input | 1 | Install a tag |
| fill_vset | input | 7 | Set to fill |
| fill_ptag | input | 19 | Physical tag PA[31:13] to install |
| flush | input | 1 | Invalidate all lines |
| rsp_valid | output | 1 | Result present |
| rsp_hit | output | 1 | Lookup hit |
| rsp_way | output | 4 | Hitting way, 0 otherwise |
| rsp_colour_err | output | 1 | Virtual and physical colour bits disagree |

## Verification
The concurrency that matters is a fill and a lookup landing on the same set in the same cycle. The bench drives both on one edge. It expects a miss from that lookup and a hit in the pointer's way from the lookup issued right after. A flush and a fill sharing a cycle is the second collision. The bench checks that the fill vanished and that the next fill still lands on the unchanged pointer. Expected tags, ways and colour outcomes come from a bench-side model of tags, valid bits and pointers, swept over every set and way and every physical colour.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
    localparam int unsigned DEF_PA_W   = 32;
    localparam int unsigned DEF_WAYS   = 16;
    localparam int unsigned DEF_LINE_W = 6;
    localparam int unsigned DEF_SET_W  = 7;
    localparam int unsigned DEF_PAGE_W = 10;

    typedef struct packed {
        logic hit;
        logic colour_err;
    } vipt_flags_t;
endpackage

// File: rtl/vipt_tag_store.sv
module vipt_tag_store #(
    parameter int unsigned SET_W = 7,
    parameter int unsigned WAYS  = 16,
    parameter int unsigned TAG_W = 19,
    localparam int unsigned SETS  = 1 << SET_W,
    localparam int unsigned WAY_W = $clog2(WAYS)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        flush,
    input  logic                        rd_en,
    input  logic [SET_W-1:0]            rd_set,
    input  logic                        fill_en,
    input  logic [SET_W-1:0]            fill_set,
    input  logic [TAG_W-1:0]            fill_tag,
    output logic [WAYS-1:0][TAG_W-1:0]  rd_tag,
    output logic [WAYS-1:0]             rd_vld
);
    logic [WAYS-1:0][TAG_W-1:0] tag_q [SETS];
    logic [WAYS-1:0]            vld_q [SETS];
    logic [WAY_W-1:0]           ptr_q [SETS];

    logic [WAYS-1:0]  fill_hits;
    logic             fill_resident;
    logic [WAY_W-1:0] fill_res_way;
    logic [WAY_W-1:0] fill_way;
    logic             fill_go;

    // look for the tag already living in the fill's set
    always_comb begin
        fill_hits    = '0;
        fill_res_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            fill_hits[w] = vld_q[fill_set][w] && (tag_q[fill_set][w] == fill_tag);
            if (fill_hits[w]) fill_res_way = WAY_W'(w);
        end
        fill_resident = |fill_hits;
        fill_way      = fill_resident ? fill_res_way : ptr_q[fill_set];
        fill_go       = fill_en && !flush;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
                ptr_q[s] <= '0;
            end
        end else if (flush) begin
            for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
        end else if (fill_go) begin
            vld_q[fill_set][fill_way] <= 1'b1;
            if (!fill_resident) begin
                ptr_q[fill_set] <= (ptr_q[fill_set] == WAY_W'(WAYS - 1)) ? '0
                                 : ptr_q[fill_set] + WAY_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (fill_go) tag_q[fill_set][fill_way] <= fill_tag;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_vld <= '0;
            rd_tag <= '0;
        end else if (rd_en) begin
            rd_vld <= vld_q[rd_set];
            rd_tag <= tag_q[rd_set];
        end
    end
endmodule

// File: rtl/vipt_tag_match.sv
module vipt_tag_match #(
    parameter int unsigned WAYS  = 16,
    parameter int unsigned TAG_W = 19,
    localparam int unsigned WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
    input  logic [WAYS-1:0]            way_vld,
    input  logic [TAG_W-1:0]           ptag,
    input  logic                       enable,
    output logic [WAYS-1:0]            hits,
    output logic                       any_hit,
    output logic [WAY_W-1:0]           hit_way
);
    always_comb begin
        hits    = '0;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            hits[w] = enable && way_vld[w] && (way_tag[w] == ptag);
            if (hits[w]) hit_way = hit_way | WAY_W'(w);
        end
        any_hit = |hits;
    end
endmodule

// File: rtl/vipt_lookup.sv
module vipt_lookup
    import vipt_pkg::*;
#(
    parameter int unsigned PA_W   = DEF_PA_W,
    parameter int unsigned WAYS   = DEF_WAYS,
    parameter int unsigned LINE_W = DEF_LINE_W,
    parameter int unsigned SET_W  = DEF_SET_W,
    parameter int unsigned PAGE_W = DEF_PAGE_W,
    localparam int unsigned WAY_W = $clog2(WAYS),
    localparam int unsigned COL_W = LINE_W + SET_W - PAGE_W,
    localparam int unsigned PFN_W = PA_W - PAGE_W,
    localparam int unsigned TAG_W = PFN_W - COL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [SET_W-1:0] req_vset,
    input  logic [PFN_W-1:0] tr_pfn,
    input  logic             fill_valid,
    input  logic [SET_W-1:0] fill_vset,
    input  logic [TAG_W-1:0] fill_ptag,
    input  logic             flush,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [WAY_W-1:0] rsp_way,
    output logic             rsp_colour_err
);
    logic [WAYS-1:0][TAG_W-1:0] rd_tag;
    logic [WAYS-1:0]            rd_vld;
    logic                       s1_valid;
    logic [COL_W-1:0]           s1_colour;
    logic                       colour_ok;
    logic [WAYS-1:0]            way_hits;
    logic                       any_hit;
    logic [WAY_W-1:0]           hit_way;
    vipt_flags_t                flags_d;

    vipt_tag_store #(.SET_W(SET_W), .WAYS(WAYS), .TAG_W(TAG_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .rd_en    (req_valid),
        .rd_set   (req_vset),
        .fill_en  (fill_valid),
        .fill_set (fill_vset),
        .fill_tag (fill_ptag),
        .rd_tag   (rd_tag),
        .rd_vld   (rd_vld)
    );

    // stage 1: remember the virtual colour while translation completes
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid  <= 1'b0;
            s1_colour <= '0;
        end else begin
            s1_valid <= req_valid;
            if (req_valid) s1_colour <= req_vset[SET_W-1 -: COL_W];
        end
    end

    assign colour_ok = (tr_pfn[COL_W-1:0] == s1_colour);

    vipt_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
        .way_tag (rd_tag),
        .way_vld (rd_vld),
        .ptag    (tr_pfn[PFN_W-1:COL_W]),
        .enable  (colour_ok),
        .hits    (way_hits),
        .any_hit (any_hit),
        .hit_way (hit_way)
    );

    always_comb begin
        flags_d.hit        = s1_valid && any_hit;
        flags_d.colour_err = s1_valid && !colour_ok;
    end

    // stage 2: registered response
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid      <= 1'b0;
            rsp_hit        <= 1'b0;
            rsp_way        <= '0;
            rsp_colour_err <= 1'b0;
        end else begin
            rsp_valid      <= s1_valid;
            rsp_hit        <= flags_d.hit;
            rsp_way        <= flags_d.hit ? hit_way : '0;
            rsp_colour_err <= flags_d.colour_err;
        end
    end
endmodule

// File: rtl/vipt_lookup_chk.sv
module vipt_lookup_chk #(
    parameter int unsigned WAYS  = 16,
    parameter int unsigned WAY_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             flush,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic [WAY_W-1:0] rsp_way,
    input logic             rsp_colour_err,
    input logic [WAYS-1:0]  way_hits
);
    AST_RSP_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid, 2)); // R2
    AST_REQ_GETS_RSP: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> ##1 rsp_valid); // R2
    AST_COLOUR_NO_HIT: assert property (@(posedge clk) disable iff (rst)
        rsp_colour_err |-> (!rsp_hit && rsp_way == '0)); // R4
    AST_MISS_WAY_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rsp_hit |-> rsp_way == '0); // R5
    AST_FLUSHED_MISS: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && $past(flush, 3)) |-> !rsp_hit); // R8
    AST_SINGLE_WAY: assert property (@(posedge clk) disable iff (rst)
        $onehot0(way_hits)); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (!rsp_hit && !rsp_colour_err && rsp_way == '0)); // R11
endmodule

bind vipt_lookup vipt_lookup_chk #(.WAYS(WAYS), .WAY_W(WAY_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .flush          (flush),
    .rsp_valid      (rsp_valid),
    .rsp_hit        (rsp_hit),
    .rsp_way        (rsp_way),
    .rsp_colour_err (rsp_colour_err),
    .way_hits       (way_hits)
);

// File: tb/vipt_lookup_test.sv
module vipt_lookup_test;
    localparam int SETS  = 128;
    localparam int WAYS  = 16;
    localparam int TAG_W = 19;
    localparam int PFN_W = 22;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic [6:0] req_vset = '0;
    logic [PFN_W-1:0] tr_pfn = '0;
    logic fill_valid = 1'b0;
    logic [6:0] fill_vset = '0;
    logic [TAG_W-1:0] fill_ptag = '0;
    logic flush = 1'b0;
    logic rsp_valid, rsp_hit, rsp_colour_err;
    logic [3:0] rsp_way;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;

    logic [TAG_W-1:0] m_tag [SETS][WAYS];
    bit               m_vld [SETS][WAYS];
    int               m_ptr [SETS];

    always #10 clk = ~clk;

    vipt_lookup uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_vset(req_vset),
        .tr_pfn(tr_pfn), .fill_valid(fill_valid), .fill_vset(fill_vset),
        .fill_ptag(fill_ptag), .flush(flush), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_way(rsp_way), .rsp_colour_err(rsp_colour_err)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: act cycles=%0d exp below 150000", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: act=%0d exp=%0d", rq, act, exp);
        end
    endtask

    function automatic logic [TAG_W-1:0] tag_of(input int s, input int k);
        return TAG_W'(s * 37 + k * 1031 + 5);
    endfunction

    function automatic void model_fill(input int s, input logic [TAG_W-1:0] t);
        for (int w = 0; w < WAYS; w++)
            if (m_vld[s][w] && m_tag[s][w] == t) return;
        m_tag[s][m_ptr[s]] = t;
        m_vld[s][m_ptr[s]] = 1'b1;
        m_ptr[s] = (m_ptr[s] + 1) % WAYS;
    endfunction

    task automatic fill(input int s, input logic [TAG_W-1:0] t);
        @(negedge clk);
        fill_valid = 1'b1; fill_vset = 7'(s); fill_ptag = t;
        model_fill(s, t);
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic look(input int s, input logic [TAG_W-1:0] t, input int pc, input string rq);
        bit e_err, e_hit;
        int e_way;
        e_err = (pc != (s >> 4));
        e_hit = 1'b0; e_way = 0;
        if (!e_err)
            for (int w = 0; w < WAYS; w++)
                if (m_vld[s][w] && m_tag[s][w] == t) begin e_hit = 1'b1; e_way = w; end
        @(negedge clk);
        req_valid = 1'b1; req_vset = 7'(s);
        @(negedge clk);
        req_valid = 1'b0; tr_pfn = {t, 3'(pc)};
        @(negedge clk);
        check(rsp_valid == 1'b1, {rq, " R2 valid"}, int'(rsp_valid), 1);
        check(rsp_hit == e_hit, {rq, " hit"}, int'(rsp_hit), int'(e_hit));
        check(int'(rsp_way) == e_way, {rq, " way"}, int'(rsp_way), e_way);
        check(rsp_colour_err == e_err, {rq, " colour"}, int'(rsp_colour_err), int'(e_err));
    endtask

    initial begin
        for (int s = 0; s < SETS; s++) begin
            m_ptr[s] = 0;
            for (int w = 0; w < WAYS; w++) begin m_vld[s][w] = 1'b0; m_tag[s][w] = '0; end
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(rsp_valid == 1'b0, "R1 rsp_valid after reset", int'(rsp_valid), 0);
        look(0, tag_of(0, 0), 0, "R1 empty set 0");
        look(127, tag_of(127, 0), 7, "R1 empty set 127");
        @(negedge clk);
        check(rsp_valid == 1'b0, "R2 single-cycle response", int'(rsp_valid), 0);
        check(rsp_hit == 1'b0 && rsp_way == 4'd0 && rsp_colour_err == 1'b0,
              "R11 idle outputs", int'({rsp_hit, rsp_way, rsp_colour_err}), 0);

        // R6 fill every way of every set; R3 R10 find each one
        for (int s = 0; s < SETS; s++)
            for (int k = 0; k < WAYS; k++) fill(s, tag_of(s, k));
        for (int s = 0; s < SETS; s++)
            for (int k = 0; k < WAYS; k++) look(s, tag_of(s, k), s >> 4, "R3 R6 R10 sweep");
        look(20, tag_of(20, 99), 1, "R5 absent tag");

        // R6 wrap and independent pointers
        fill(5, tag_of(5, 200));
        look(5, tag_of(5, 0), 0, "R6 evicted way 0");
        look(5, tag_of(5, 200), 0, "R6 wrapped to way 0");
        fill(6, tag_of(6, 201));
        look(6, tag_of(6, 201), 0, "R6 own pointer set 6");
        look(6, tag_of(6, 1), 0, "R6 set 6 way 1 kept");

        // R7 resident refill keeps way and pointer
        fill(5, tag_of(5, 3));
        look(5, tag_of(5, 3), 0, "R7 resident way 3");
        fill(5, tag_of(5, 202));
        look(5, tag_of(5, 202), 0, "R7 pointer unchanged -> way 1");

        // R4 every physical colour against every set
        for (int s = 0; s < SETS; s++)
            for (int pc = 0; pc < 8; pc++) look(s, tag_of(s, 4), pc, "R4 colour sweep");

        // R9 fill and lookup on the same set in one cycle
        @(negedge clk);
        fill_valid = 1'b1; fill_vset = 7'd9; fill_ptag = tag_of(9, 300);
        req_valid = 1'b1; req_vset = 7'd9;
        @(negedge clk);
        fill_valid = 1'b0; req_valid = 1'b0; tr_pfn = {tag_of(9, 300), 3'd0};
        @(negedge clk);
        check(rsp_valid == 1'b1 && rsp_hit == 1'b0, "R9 same-cycle fill unseen",
              int'(rsp_hit), 0);
        model_fill(9, tag_of(9, 300));
        look(9, tag_of(9, 300), 0, "R9 next lookup sees fill");

        // R8 flush with a colliding fill
        @(negedge clk);
        flush = 1'b1; fill_valid = 1'b1; fill_vset = 7'd9; fill_ptag = tag_of(9, 301);
        @(negedge clk);
        flush = 1'b0; fill_valid = 1'b0;
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) m_vld[s][w] = 1'b0;
        look(9, tag_of(9, 301), 0, "R8 dropped fill");
        look(9, tag_of(9, 300), 0, "R8 flushed line");
        for (int s = 0; s < SETS; s += 9) look(s, tag_of(s, 7), s >> 4, "R8 all invalid");
        fill(9, tag_of(9, 302));
        look(9, tag_of(9, 302), 0, "R8 pointer kept -> way 1");

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule